// File: doc/BRIEF.md
# Fault-Tolerant Sparse Prefix Adder

This block adds two WIDTH-bit operands and a carry-in, and returns the sum and carry-out. It is a sparse parallel-prefix adder. The operands are cut into segments of SEG bits. A logarithmic prefix tree works on one generate/propagate pair per segment and produces a carry only at each segment boundary. Inside each segment, small ripple-carry adders build the sum bits from that segment's incoming carry.

Each segment ripple adder exists three times, and bitwise majority voters choose the segment sum, the segment carry-out and the segment generate/propagate pair that feeds the tree. Three candidates decide each boundary carry. The first is the carry from the tree. The second is a short recombination of the voted segment pair with the voted carry of the boundary below, which is a redundant path that the tree already implies. The third is the voted ripple carry-out. A majority of the three is taken. So any single stuck fault in one ripple copy or in one tree node is masked. Any voter that sees its inputs disagree raises a combinational error flag.

Test-only inputs force a stuck value onto one fault site. Tie them to zero in normal use.

Top module: `ft_sparse_adder`

## Requirements
- R1: With no fault selected, {cout_o, sum_o} equals a_i + b_i + cin_i for any operands.
- R2: A carry entering at cin_i propagates through every segment boundary to cout_o (a_i all ones, b_i zero, cin_i 1 gives sum_o 0 and cout_o 1), and the carry computed by the tree agrees with the ripple-derived carry at every boundary.
- R3: With fault_sel_i all zero, err_o is 0 for any operands.
- R4: Forcing any single ripple copy (every sum bit, carry-out, generate and propagate of that copy replaced by fault_val_i) leaves sum_o and cout_o correct.
- R5: Forcing the generate output of any single prefix-tree node to fault_val_i leaves sum_o and cout_o correct.
- R6: When a forced ripple copy produces sum bits that differ from the true segment sum, err_o is 1. For example, copy 0 of segment s forced to 0 with a_i = 1 << (s*SEG), b_i = 0 and cin_i = 0.
- R7: When a forced tree node drives a wrong boundary carry, err_o is 1. With a_i = b_i = 0 and cin_i = 0, forcing the last-level node of the highest segment to 1 raises err_o, while sum_o and cout_o stay 0.
- R8: fault_sel_i is one-hot or zero. Bit s*3+k selects copy k (0..2) of segment s. Bit 3*NSEG + (l-1)*NSEG + i selects tree level l (1..LVL), node i. For the defaults (WIDTH 16, SEG 4), NSEG = 4, LVL = 2 and there are 20 sites.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| fault_sel_i | input | NSITE | One-hot fault site select (test only, zero in use) |
| fault_val_i | input | 1 | Stuck value forced onto the selected site |
| sum_o | output | WIDTH | Voted sum |
| cout_o | output | 1 | Voted carry-out |
| err_o | output | 1 | Some voter saw disagreement |

## Verification
The hardest case to reach from the ports is a fault that really corrupts one internal path while the outputs stay correct. A forced value often equals the true value, and then nothing disagrees. The stimulus sweeps every site with both stuck values over random operands to check masking. It also uses operands built so that the forced value must differ from the true value, either a nonzero segment sum under a copy stuck at 0 or an all-zero addition under a tree node stuck at 1, so that err_o must rise while sum_o stays exact.

// File: rtl/ft_adder_pkg.sv
package ft_adder_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // hi covers the upper span, lo the span just below it
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  function automatic logic carry_of(input gp_t x, input logic c);
    return x.g | (x.p & c);
  endfunction

endpackage

// File: rtl/seg_copy.sv
module seg_copy #(
  parameter int SEG = 4
) (
  input  logic [SEG-1:0] a,
  input  logic [SEG-1:0] b,
  input  logic           cin,
  input  logic           force_en,
  input  logic           force_val,
  output logic [SEG-1:0] sum,
  output logic           cout,
  output logic           grp_g,
  output logic           grp_p
);

  function automatic logic [SEG:0] ripple(input logic [SEG-1:0] x,
                                          input logic [SEG-1:0] y,
                                          input logic c0);
    logic [SEG:0] r;
    logic c;
    c = c0;
    for (int i = 0; i < SEG; i++) begin
      r[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    r[SEG] = c;
    return r;
  endfunction

  logic [SEG:0] add_c;
  logic [SEG:0] add_0;

  always_comb begin
    add_c = ripple(a, b, cin);
    add_0 = ripple(a, b, 1'b0);
    if (force_en) begin
      sum   = {SEG{force_val}};
      cout  = force_val;
      grp_g = force_val;
      grp_p = force_val;
    end else begin
      sum   = add_c[SEG-1:0];
      cout  = add_c[SEG];
      grp_g = add_0[SEG];
      grp_p = &(a ^ b);
    end
  end

endmodule

// File: rtl/seg_tmr.sv
module seg_tmr
  import ft_adder_pkg::*;
#(
  parameter int SEG = 4
) (
  input  logic [SEG-1:0] a,
  input  logic [SEG-1:0] b,
  input  logic           cin,
  input  logic [2:0]     inj,
  input  logic           inj_val,
  output logic [SEG-1:0] sum_v,
  output logic           cout_v,
  output gp_t            gp_v,
  output logic           mismatch
);

  logic [2:0][SEG-1:0] s_c;
  logic [2:0]          co_c;
  logic [2:0]          g_c;
  logic [2:0]          p_c;

  for (genvar k = 0; k < 3; k++) begin : g_copy
    seg_copy #(.SEG(SEG)) u_copy (
      .a        (a),
      .b        (b),
      .cin      (cin),
      .force_en (inj[k]),
      .force_val(inj_val),
      .sum      (s_c[k]),
      .cout     (co_c[k]),
      .grp_g    (g_c[k]),
      .grp_p    (p_c[k])
    );
  end

  logic sum_dis;
  logic side_dis;

  always_comb begin
    for (int i = 0; i < SEG; i++) begin
      sum_v[i] = maj3(s_c[0][i], s_c[1][i], s_c[2][i]);
    end
    cout_v   = maj3(co_c[0], co_c[1], co_c[2]);
    gp_v.g   = maj3(g_c[0], g_c[1], g_c[2]);
    gp_v.p   = maj3(p_c[0], p_c[1], p_c[2]);
    sum_dis  = (s_c[0] != s_c[1]) || (s_c[0] != s_c[2]);
    side_dis = (co_c[0] != co_c[1]) || (co_c[0] != co_c[2]) ||
               (g_c[0] != g_c[1])   || (g_c[0] != g_c[2])   ||
               (p_c[0] != p_c[1])   || (p_c[0] != p_c[2]);
    mismatch = sum_dis || side_dis;
  end

endmodule

// File: rtl/sparse_tree.sv
module sparse_tree
  import ft_adder_pkg::*;
#(
  parameter int NSEG = 4,
  parameter int LVL  = 2
) (
  input  gp_t [NSEG-1:0]     leaf,
  input  logic               cin,
  input  logic [LVL*NSEG-1:0] inj,
  input  logic               inj_val,
  output logic [NSEG-1:0]    tc
);

  gp_t [LVL:0][NSEG-1:0] st;

  assign st[0] = leaf;

  for (genvar l = 1; l <= LVL; l++) begin : g_lvl
    localparam int D = 1 << (l - 1);
    for (genvar i = 0; i < NSEG; i++) begin : g_node
      gp_t raw;
      if (i >= D) begin : g_merge
        assign raw = gp_merge(st[l-1][i], st[l-1][i-D]);
      end else begin : g_pass
        assign raw = st[l-1][i];
      end
      assign st[l][i].g = inj[(l-1)*NSEG + i] ? inj_val : raw.g;
      assign st[l][i].p = raw.p;
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_out
    assign tc[i] = carry_of(st[LVL][i], cin);
  end

endmodule

// File: rtl/ft_sparse_adder.sv
module ft_sparse_adder
  import ft_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG   = 4,
  localparam int NSEG  = WIDTH / SEG,
  localparam int LVL   = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int NSITE = 3 * NSEG + LVL * NSEG
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [NSITE-1:0] fault_sel_i,
  input  logic             fault_val_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             err_o
);

  gp_t  [NSEG-1:0] seg_gp;
  logic [NSEG-1:0] rip_cy;
  logic [NSEG-1:0] tree_cy;
  logic [NSEG-1:0] side_cy;
  logic [NSEG:0]   bnd_cy;
  logic [NSEG-1:0] seg_mis;
  logic [NSEG-1:0] cy_mis;

  assign bnd_cy[0] = cin_i;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    seg_tmr #(.SEG(SEG)) u_seg (
      .a       (a_i[s*SEG +: SEG]),
      .b       (b_i[s*SEG +: SEG]),
      .cin     (bnd_cy[s]),
      .inj     (fault_sel_i[s*3 +: 3]),
      .inj_val (fault_val_i),
      .sum_v   (sum_o[s*SEG +: SEG]),
      .cout_v  (rip_cy[s]),
      .gp_v    (seg_gp[s]),
      .mismatch(seg_mis[s])
    );

    assign side_cy[s]  = carry_of(seg_gp[s], bnd_cy[s]);
    assign bnd_cy[s+1] = maj3(tree_cy[s], side_cy[s], rip_cy[s]);
    assign cy_mis[s]   = (tree_cy[s] != side_cy[s]) || (tree_cy[s] != rip_cy[s]);
  end

  sparse_tree #(.NSEG(NSEG), .LVL(LVL)) u_tree (
    .leaf   (seg_gp),
    .cin    (cin_i),
    .inj    (fault_sel_i[NSITE-1:3*NSEG]),
    .inj_val(fault_val_i),
    .tc     (tree_cy)
  );

  assign cout_o = bnd_cy[NSEG];
  assign err_o  = (|seg_mis) | (|cy_mis);

endmodule

// File: rtl/ft_sparse_adder_chk.sv
module ft_sparse_adder_chk #(
  parameter int WIDTH = 16,
  parameter int NSEG  = 4,
  parameter int NSITE = 20
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [NSITE-1:0] fault_sel_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             err_o,
  input logic [NSEG-1:0]  tree_cy,
  input logic [NSEG-1:0]  rip_cy
);

  logic [WIDTH:0] ref_sum;
  logic           no_fault;
  logic           rip_site;
  logic           tree_site;

  always_comb begin
    ref_sum   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    no_fault  = (fault_sel_i == '0);
    rip_site  = $onehot(fault_sel_i[3*NSEG-1:0]) && (fault_sel_i[NSITE-1:3*NSEG] == '0);
    tree_site = $onehot(fault_sel_i[NSITE-1:3*NSEG]) && (fault_sel_i[3*NSEG-1:0] == '0);

    p_ref_r1: assert (!no_fault || ({cout_o, sum_o} == ref_sum))
      else $error("R1 sum mismatch with no fault");
    p_carry_agree_r2: assert (!no_fault || (tree_cy == rip_cy))
      else $error("R2 tree and ripple carries disagree");
    p_quiet_r3: assert (!no_fault || !err_o)
      else $error("R3 error flag raised with no fault");
    p_mask_copy_r4: assert (!rip_site || ({cout_o, sum_o} == ref_sum))
      else $error("R4 ripple copy fault not masked");
    p_mask_tree_r5: assert (!tree_site || ({cout_o, sum_o} == ref_sum))
      else $error("R5 tree node fault not masked");
  end

endmodule

bind ft_sparse_adder ft_sparse_adder_chk #(
  .WIDTH(WIDTH),
  .NSEG (NSEG),
  .NSITE(NSITE)
) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .cin_i      (cin_i),
  .fault_sel_i(fault_sel_i),
  .sum_o      (sum_o),
  .cout_o     (cout_o),
  .err_o      (err_o),
  .tree_cy    (tree_cy),
  .rip_cy     (rip_cy)
);

// File: tb/tb_ft_sparse_adder.sv
module tb_ft_sparse_adder;

  localparam int W     = 16;
  localparam int SG    = 4;
  localparam int NS    = W / SG;
  localparam int LV    = 2;
  localparam int SITES = 3 * NS + LV * NS;

  typedef struct {
    logic [W-1:0] exp_sum;
    logic         exp_cout;
    logic         chk_err;
    logic         exp_err;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]     a, b;
  logic             cin;
  logic [SITES-1:0] fsel;
  logic             fval;
  logic [W-1:0]     sum;
  logic             cout;
  logic             err;

  item_t q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  ft_sparse_adder #(.WIDTH(W), .SEG(SG)) dut (
    .a_i(a), .b_i(b), .cin_i(cin),
    .fault_sel_i(fsel), .fault_val_i(fval),
    .sum_o(sum), .cout_o(cout), .err_o(err)
  );

  task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb_,
                       input logic tc, input logic [SITES-1:0] ts,
                       input logic tv, input logic ce, input logic ee,
                       input string tag);
    item_t it;
    logic [W:0] r;
    @(posedge clk);
    a = ta; b = tb_; cin = tc; fsel = ts; fval = tv;
    r = {1'b0, ta} + {1'b0, tb_} + {{W{1'b0}}, tc};
    it.exp_sum  = r[W-1:0];
    it.exp_cout = r[W];
    it.chk_err  = ce;
    it.exp_err  = ee;
    it.tag      = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if ({cout, sum} !== {it.exp_cout, it.exp_sum}) begin
          bad++;
          $display("FAIL %s: sum/cout actual=%h/%b expected=%h/%b",
                   it.tag, sum, cout, it.exp_sum, it.exp_cout);
        end
        if (it.chk_err) begin
          total++;
          if (err !== it.exp_err) begin
            bad++;
            $display("FAIL %s: err actual=%b expected=%b", it.tag, err, it.exp_err);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    a = '0; b = '0; cin = 1'b0; fsel = '0; fval = 1'b0;
    // idle state: zero inputs give zero outputs, quiet flag (R1, R3)
    drive('0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R1 idle");
    // carry through all boundaries (R2)
    drive({W{1'b1}}, '0, 1'b1, '0, 1'b0, 1'b1, 1'b0, "R2 full propagate");
    drive({W{1'b1}}, {W{1'b1}}, 1'b1, '0, 1'b0, 1'b1, 1'b0, "R2 max plus max");
    drive(16'h0FFF, 16'h0001, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R2 three boundaries");
    // random, no fault (R1, R3)
    for (int n = 0; n < 200; n++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), '0, 1'b0, 1'b1, 1'b0, "R1 R3 random");
    end
    // every single site, both stuck values (R4 copies, R5 tree, R8 index)
    for (int s = 0; s < SITES; s++) begin
      for (int v = 0; v < 2; v++) begin
        for (int n = 0; n < 20; n++) begin
          drive(W'($urandom), W'($urandom), 1'($urandom), SITES'(1) << s, 1'(v),
                1'b0, 1'b0, (s < 3 * NS) ? "R4 R8 copy fault" : "R5 R8 tree fault");
        end
        drive({W{1'b1}}, '0, 1'b1, SITES'(1) << s, 1'(v), 1'b0, 1'b0,
              (s < 3 * NS) ? "R4 copy fault carry chain" : "R5 tree fault carry chain");
      end
    end
    // flagged copy fault: copy k of segment s stuck at 0, nonzero segment sum (R6)
    for (int s = 0; s < NS; s++) begin
      for (int k = 0; k < 3; k++) begin
        drive(W'(1) << (s * SG), '0, 1'b0, SITES'(1) << (s * 3 + k), 1'b0,
              1'b1, 1'b1, "R6 copy stuck low flagged");
      end
    end
    // flagged tree fault: last-level node of top segment stuck at 1 (R7)
    drive('0, '0, 1'b0, SITES'(1) << (3 * NS + (LV - 1) * NS + NS - 1), 1'b1,
          1'b1, 1'b1, "R7 tree node stuck high flagged");
    drive('0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R3 quiet after faults");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule